// File: doc/BRIEF.md
# Converter Serial Slave Front End

This block is the two-wire serial slave that sits in front of an 8-bit data converter. It watches the clock and data lines, recognises start and stop conditions, and takes a 7-bit address. The top four address bits are fixed at `1001`. The lower three come from strap inputs. When the address matches, the block acknowledges it, and the read/write bit sets the direction of the rest of the transfer.

In a write transfer the first byte after the address sets the control register. Each later byte replaces the output-DAC code. In a read transfer the block returns one byte per slot, and every byte is the result of the conversion started one slot earlier. A conversion is started by a one-cycle `conv_start` pulse. The pulse fires when the falling clock edge closes an acknowledged slot. The engine hands its result back through `adc_done`/`adc_result`.

The data line is modelled as an open-drain pull-down enable. Both bus lines are sampled through a two-flop synchroniser clocked by the system clock.

Top module: `conv_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `1001` followed by the three strap bits, MSB first, with bit 0 giving the direction (1 = read). On a mismatch it gives no acknowledge and ignores every later byte until the next start condition, so the control and DAC outputs keep their values.
- R2: In a write transfer, the first byte after the address is stored on `ctrl_o`.
- R3: Each later byte of the same write transfer overwrites `dac_o`, and `ctrl_o` does not change.
- R4: The block pulls the data line low for the whole ninth clock after a matched address and after every byte it receives.
- R5: The first byte read after reset is 0x80.
- R6: Each acknowledged read slot ends on a falling clock edge. That edge, including the one after the address acknowledge, produces exactly one single-cycle `conv_start` pulse. Every read byte after the first one of a transfer equals the result of the conversion started one slot earlier.
- R7: After a master NACK on a read byte, the block releases the data line and starts no further conversion.
- R8: A stop condition ends a write transfer, and bytes clocked afterwards without a start are ignored. After a repeated start, the first byte that follows the address is a control byte again.
- R9: While reset is asserted the block holds `ctrl_o` and `dac_o` at 0, leaves the data line released and keeps `conv_start` low.
- R10: Read bytes go out MSB first. `sda_oe` is high only for 0 bits, and the block changes it only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Programmable low address bits |
| adc_done | input | 1 | One-cycle strobe from the engine: result ready |
| adc_result | input | 8 | Conversion result, valid with adc_done |
| conv_start | output | 1 | One-cycle request to start a conversion |
| ctrl_o | output | 8 | Control register |
| dac_o | output | 8 | DAC data register |

## Verification
A wrong state in the receive path shows up within one byte. A wrong bit count or address compare moves or drops the acknowledge in the ninth clock. A byte-index error puts data on the wrong one of `ctrl_o` and `dac_o`. A fault in the read pipeline appears on the line in the very byte where it occurs: a missed or extra `conv_start` shifts every later byte of the sequence by one position. A stuck transmit state keeps the data line low after the NACK, and that stops the master from sending a stop condition.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e        st;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              is_addr;
        logic              rd;
        logic              first;
        logic              conv;
        logic              wr_ctrl;
        logic              wr_dac;
    } fsm_s;
endpackage

// File: rtl/conv_i2c_sync.sv
module conv_i2c_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    localparam int CHAIN = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[CHAIN-2:0], raw_i[g]};
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall_o[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/conv_i2c_regs.sv
module conv_i2c_regs #(
    parameter int               DW         = 8,
    parameter logic [DW-1:0]    HOLD_RESET = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_dac,
    input  logic [DW-1:0] wdata,
    input  logic          adc_done,
    input  logic [DW-1:0] adc_result,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] dac_o,
    output logic [DW-1:0] hold_o
);
    logic [DW-1:0] ctrl_d, ctrl_q, dac_d, dac_q, hold_d, hold_q;

    always_comb begin
        ctrl_d = wr_ctrl  ? wdata      : ctrl_q;
        dac_d  = wr_dac   ? wdata      : dac_q;
        hold_d = adc_done ? adc_result : hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dac_q  <= '0;
            hold_q <= HOLD_RESET;
        end else begin
            ctrl_q <= ctrl_d;
            dac_q  <= dac_d;
            hold_q <= hold_d;
        end
    end

    assign ctrl_o = ctrl_q;
    assign dac_o  = dac_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/conv_i2c_slave.sv
module conv_i2c_slave
    import conv_i2c_pkg::*;
#(
    parameter int            STRAP_W     = 3,
    parameter logic [3:0]    ADDR_FIXED  = 4'b1001,
    parameter int            SYNC_STAGES = 2,
    parameter logic [7:0]    FIRST_READ  = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               adc_done,
    input  logic [BYTE_W-1:0]  adc_result,
    output logic               conv_start,
    output logic [BYTE_W-1:0]  ctrl_o,
    output logic [BYTE_W-1:0]  dac_o
);
    localparam int              ADDR_W    = 4 + STRAP_W;
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

    logic [1:0] lvl, rise, fall;
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] hold;
    fsm_s q, d;

    conv_i2c_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = rise[0];
    assign scl_fall  = fall[0];
    assign start_det = scl_lvl & fall[1];
    assign stop_det  = scl_lvl & rise[1];

    conv_i2c_regs #(.DW(BYTE_W), .HOLD_RESET(FIRST_READ)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (q.wr_ctrl),
        .wr_dac     (q.wr_dac),
        .wdata      (q.shreg),
        .adc_done   (adc_done),
        .adc_result (adc_result),
        .ctrl_o     (ctrl_o),
        .dac_o      (dac_o),
        .hold_o     (hold)
    );

    always_comb begin
        d         = q;
        d.conv    = 1'b0;
        d.wr_ctrl = 1'b0;
        d.wr_dac  = 1'b0;
        if (start_det) begin
            d.st      = ST_RX;
            d.cnt     = '0;
            d.is_addr = 1'b1;
        end else if (stop_det) begin
            d.st = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt != BITS_FULL) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_lvl};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_FULL) begin
                        if (q.is_addr) begin
                            if (q.shreg[BYTE_W-1:1] == ADDR_W'({ADDR_FIXED, strap_i})) begin
                                d.st      = ST_ACK;
                                d.rd      = q.shreg[0];
                                d.first   = 1'b1;
                                d.is_addr = 1'b0;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st      = ST_ACK;
                            d.wr_ctrl = q.first;
                            d.wr_dac  = ~q.first;
                            d.first   = 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st    = ST_TX;
                            d.shreg = hold;
                            d.conv  = 1'b1;
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS_LAST) begin
                            d.st = ST_MACK;
                        end else begin
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && sda_lvl) begin
                        d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        d.st    = ST_TX;
                        d.shreg = hold;
                        d.cnt   = '0;
                        d.conv  = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, shreg: '0, cnt: '0, is_addr: 1'b0, rd: 1'b0,
                   first: 1'b0, conv: 1'b0, wr_ctrl: 1'b0, wr_dac: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe     = (q.st == ST_ACK) | ((q.st == ST_TX) & ~q.shreg[BYTE_W-1]);
    assign conv_start = q.conv;
endmodule

// File: rtl/conv_i2c_slave_chk.sv
module conv_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       conv_start,
    input logic [7:0] ctrl_o,
    input logic [7:0] dac_o
);
    AST_CONV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R6
    AST_CTRL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> !scl_i); // R2
    AST_DAC_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_o) |-> !scl_i); // R3
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R10
    AST_CTRL_DAC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> $stable(dac_o)); // R3
endmodule

bind conv_i2c_slave conv_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe     (sda_oe),
    .conv_start (conv_start),
    .ctrl_o     (ctrl_o),
    .dac_o      (dac_o)
);

// File: tb/conv_i2c_slave_test.sv
module conv_i2c_slave_test;
    localparam int H = 10;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, conv_start, adc_done;
    logic [7:0] adc_result, ctrl_o, dac_o;
    int vectors = 0, miscompares = 0;
    int starts_seen = 0, eng_cnt = 0, n_started = 0;
    int exp_conv = 0;
    logic [7:0] exp_hold = 8'h80;
    logic [7:0] pending = 8'h00;

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    conv_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_i(STRAP), .adc_done(adc_done), .adc_result(adc_result),
        .conv_start(conv_start), .ctrl_o(ctrl_o), .dac_o(dac_o)
    );

    function automatic logic [7:0] conv_val(input int k);
        return 8'h37 + 8'(k * 41);
    endfunction

    // conversion engine model: answers three cycles after each request
    always @(posedge clk) begin
        adc_done <= 1'b0;
        if (eng_cnt != 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) begin
                adc_done   <= 1'b1;
                adc_result <= pending;
            end
        end
        if (conv_start) begin
            starts_seen <= starts_seen + 1;
            n_started   <= n_started + 1;
            pending     <= conv_val(n_started + 1);
            eng_cnt     <= 3;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_n(H);
        scl = 1'b1;   wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl = 1'b0;   wait_n(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_n(H);
        scl = 1'b1;   wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic byte_w(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(H);
            scl = 1'b1;   wait_n(H);
            scl = 1'b0;
        end
        sda_m = 1'b1; wait_n(H);
        scl = 1'b1;   wait_n(H / 2);
        acked = ~sda_line;
        wait_n(H / 2);
        scl = 1'b0;
    endtask

    task automatic byte_r(input logic m_ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_n(H);
            scl = 1'b1; wait_n(H / 2);
            v[i] = sda_line;
            wait_n(H / 2);
            scl = 1'b0;
        end
        wait_n(2);
        sda_m = ~m_ack; wait_n(H);
        scl = 1'b1;     wait_n(H);
        scl = 1'b0;     wait_n(1);
        sda_m = 1'b1;
    endtask

    task automatic t_reset;
        chk("R9 ctrl at reset", ctrl_o, 8'h00);
        chk("R9 dac at reset", dac_o, 8'h00);
        chk("R9 sda released at reset", {7'b0, sda_oe}, 8'h00);
        chk("R9 no conv at reset", {7'b0, conv_start}, 8'h00);
    endtask

    task automatic t_write;
        logic a;
        bus_start;
        byte_w({4'b1001, STRAP, 1'b0}, a); chk("R1 address ack", {7'b0, a}, 8'h01);
        byte_w(8'h45, a); chk("R4 ack on control byte", {7'b0, a}, 8'h01);
        chk("R2 control stored", ctrl_o, 8'h45);
        byte_w(8'h12, a); chk("R4 ack on dac byte", {7'b0, a}, 8'h01);
        chk("R3 dac stored", dac_o, 8'h12);
        byte_w(8'hE7, a);
        chk("R3 dac overwritten", dac_o, 8'hE7);
        chk("R3 ctrl unchanged", ctrl_o, 8'h45);
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic a;
        bus_start;
        byte_w({4'b1001, 3'b100, 1'b0}, a); chk("R1 no ack on wrong strap", {7'b0, a}, 8'h00);
        byte_w(8'h11, a); chk("R1 no ack after mismatch", {7'b0, a}, 8'h00);
        byte_w(8'h22, a);
        chk("R1 ctrl kept after mismatch", ctrl_o, 8'h45);
        chk("R1 dac kept after mismatch", dac_o, 8'hE7);
        bus_stop;
        bus_start;
        byte_w({4'b0001, STRAP, 1'b0}, a); chk("R1 no ack on wrong fixed bits", {7'b0, a}, 8'h00);
        bus_stop;
    endtask

    task automatic t_restart;
        logic a;
        bus_start;
        byte_w({4'b1001, STRAP, 1'b0}, a);
        byte_w(8'h03, a);
        chk("R8 ctrl before restart", ctrl_o, 8'h03);
        bus_start;
        byte_w({4'b1001, STRAP, 1'b0}, a); chk("R8 ack after repeated start", {7'b0, a}, 8'h01);
        byte_w(8'h07, a);
        chk("R8 first byte after restart is control", ctrl_o, 8'h07);
        chk("R8 dac untouched by control byte", dac_o, 8'hE7);
        byte_w(8'h99, a);
        chk("R8 dac after restart", dac_o, 8'h99);
        bus_stop;
        byte_w(8'h5A, a);
        chk("R8 no ack after stop", {7'b0, a}, 8'h00);
        chk("R8 dac kept after stop", dac_o, 8'h99);
    endtask

    task automatic t_read(input int nbytes, input logic check_first_reset);
        logic a;
        logic [7:0] v, e;
        bus_start;
        byte_w({4'b1001, STRAP, 1'b1}, a); chk("R1 read address ack", {7'b0, a}, 8'h01);
        for (int j = 0; j < nbytes; j++) begin
            e = (j == 0) ? exp_hold : conv_val(exp_conv + j);
            byte_r(j != nbytes - 1, v);
            if (j == 0 && check_first_reset) chk("R5 first read byte", v, 8'h80);
            else chk("R6 R10 pipelined read byte", v, e);
        end
        exp_conv = exp_conv + nbytes;
        exp_hold = conv_val(exp_conv);
        wait_n(H);
        chk("R7 sda released after nack", {7'b0, sda_oe}, 8'h00);
        chk("R6 conversion count", 8'(starts_seen), 8'(exp_conv));
        wait_n(4 * H);
        chk("R7 no conversion after nack", 8'(starts_seen), 8'(exp_conv));
        bus_stop;
    endtask

    initial begin
        wait_n(5);
        t_reset;
        rst_n = 1'b1;
        wait_n(5);
        t_write;
        t_mismatch;
        t_restart;
        t_read(2, 1'b1);
        t_read(4, 1'b0);
        t_read(1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule